// File: doc/BRIEF.md
# RTC Trimmed Seconds Divider

This block turns a 32.768 kHz oscillator tick into a one-second strobe. It corrects crystal error digitally by shortening or lengthening selected seconds. A six-bit calibration word holds a five-bit magnitude and a direction bit. The block steps through a repeating 64-minute calibration cycle. In each of the first 2N minutes of that cycle, where N is the magnitude, the first second of the minute is made shorter (to run the clock faster) or longer (to run it slower) by a fixed number of oscillator ticks.

The calibration word is taken only when a new 64-minute cycle begins, so a cycle is always trimmed by a single, consistent value. A minute strobe and the minute-in-cycle index are brought out so that the trim schedule can be observed. A separate free-running divider produces a 512 Hz square wave for measuring the crystal on the production tester. That output is never affected by calibration, so the raw crystal error can be measured whatever word is loaded.

The tick rate, seconds per minute, trim sizes and test divider are parameters. A bench can therefore run whole calibration cycles at a reduced scale.

Top module: `rtc_trim_divider`

## Requirements
- R1: A second that is not trimmed lasts exactly TICKS_PER_SEC oscillator ticks (default 32768).
- R2: `calValue[5]` = 1 selects positive calibration, and `calValue[4:0]` is the magnitude N. A trimmed second lasts TICKS_PER_SEC − POS_TRIM ticks (default 32512).
- R3: `calValue[5]` = 0 with N ≠ 0 selects negative calibration. A trimmed second lasts TICKS_PER_SEC + NEG_TRIM ticks (default 32896).
- R4: With magnitude N, exactly minutes 0 to 2N−1 of the cycle are trimmed. Minutes 62 and 63 are never trimmed, and N = 0 trims nothing.
- R5: Within a trimmed minute, only second 0 is changed. Every other second of that minute lasts TICKS_PER_SEC ticks.
- R6: The calibration word is latched only when minute 63 ends. A change made in the middle of a cycle has no effect until the next cycle starts. After reset the latched word is zero, so the first cycle is untrimmed.
- R7: `minuteInCycle` counts 0 to 63 and then wraps. It advances in the same clock as the `minStrobe` pulse, and `minStrobe` is high only together with the `secStrobe` that ends the last second of a minute.
- R8: `secStrobe` is a single-clock pulse. Only clocks with `oscTick` high advance the divider, so gaps in the tick stream stretch time in clocks but not in ticks.
- R9: `testClk512` toggles every TEST_HALF ticks (default 32, which gives 512 Hz), whatever the calibration word.
- R10: While `rstN` is low, `secStrobe`, `minStrobe`, `testClk512` and `minuteInCycle` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | One-clock enable for each oscillator cycle |
| calValue | input | 6 | Calibration word: bit 5 is the direction (1 = faster), bits 4:0 are the magnitude |
| secStrobe | output | 1 | One-clock pulse at the end of each second |
| minStrobe | output | 1 | One-clock pulse at the end of each minute |
| minuteInCycle | output | 6 | Current minute within the 64-minute calibration cycle |
| testClk512 | output | 1 | Calibration-independent 512 Hz test square wave |

## Verification
A tick counter or length select that goes wrong changes the spacing between `secStrobe` pulses within that same second. Measuring each interval in ticks therefore locates the faulty second exactly. A fault in the minute index or in the latched calibration word appears at the next minute boundary, either as a wrong `minuteInCycle` value or as a trim that lands on the wrong minute or the wrong cycle. Errors in the test divider show up at its next edge as a half period that is not TEST_HALF ticks. The bench runs complete calibration cycles at a reduced scale, which covers the cycle edges, magnitude 31 and a word changed in the middle of a cycle.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int CAL_W         = 6;
  localparam int MIN_W         = 6;
  localparam int CYCLE_MINUTES = 64;

  // strobes from control to datapath selecting the length of the running second
  typedef struct packed {
    logic trimShort;
    logic trimLong;
  } trimCtl_t;
endpackage

// File: rtl/rtc_trim_datapath.sv
module rtc_trim_datapath
  import rtc_trim_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int POS_TRIM      = 256,
  parameter int NEG_TRIM      = 128,
  parameter int TEST_HALF     = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     oscTick,
  input  trimCtl_t ctl,
  output logic     secEnd,
  output logic     testClk
);
  localparam int CNT_W      = $clog2(TICKS_PER_SEC + NEG_TRIM + 1);
  localparam int HALF_W     = $clog2(TEST_HALF + 1);
  localparam logic [CNT_W-1:0] NOM_LAST   = CNT_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(TICKS_PER_SEC - POS_TRIM - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(TICKS_PER_SEC + NEG_TRIM - 1);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(TEST_HALF - 1);

  logic [CNT_W-1:0]  tickCnt;
  logic [CNT_W-1:0]  lastIdx;
  logic [HALF_W-1:0] halfCnt;

  always_comb begin
    if (ctl.trimShort)     lastIdx = SHORT_LAST;
    else if (ctl.trimLong) lastIdx = LONG_LAST;
    else                   lastIdx = NOM_LAST;
  end

  assign secEnd = oscTick && (tickCnt == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN)          tickCnt <= '0;
    else if (secEnd)    tickCnt <= '0;
    else if (oscTick)   tickCnt <= tickCnt + 1'b1;
  end

  // free-running test divider, independent of the trim path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
      testClk <= 1'b0;
    end else if (oscTick) begin
      if (halfCnt == HALF_LAST) begin
        halfCnt <= '0;
        testClk <= ~testClk;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= lastIdx);

  // R9
  test_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(testClk) |-> $past(oscTick));

  // R2
  trim_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.trimShort && ctl.trimLong));
endmodule

// File: rtl/rtc_trim_control.sv
module rtc_trim_control
  import rtc_trim_pkg::*;
#(
  parameter int SEC_PER_MIN = 60
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secEnd,
  input  logic [CAL_W-1:0] calValue,
  output trimCtl_t         ctl,
  output logic             secStrobe,
  output logic             minStrobe,
  output logic [MIN_W-1:0] minIdx
);
  localparam int SEC_W = (SEC_PER_MIN > 2) ? $clog2(SEC_PER_MIN) : 1;
  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SEC_PER_MIN - 1);
  localparam logic [MIN_W-1:0] LAST_MIN = MIN_W'(CYCLE_MINUTES - 1);

  logic [SEC_W-1:0] secIdx;
  logic [CAL_W-1:0] calLatched;
  logic [4:0]       calMag;
  logic             calPos;
  logic             trimMinute;
  logic             trimSecond;

  assign calMag     = calLatched[4:0];
  assign calPos     = calLatched[5];
  assign trimMinute = (calMag != 5'd0) && (minIdx < {calMag, 1'b0});
  assign trimSecond = trimMinute && (secIdx == '0);

  always_comb begin
    ctl.trimShort = trimSecond && calPos;
    ctl.trimLong  = trimSecond && !calPos;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secIdx     <= '0;
      minIdx     <= '0;
      calLatched <= '0;
      secStrobe  <= 1'b0;
      minStrobe  <= 1'b0;
    end else begin
      secStrobe <= secEnd;
      minStrobe <= secEnd && (secIdx == LAST_SEC);
      if (secEnd) begin
        if (secIdx == LAST_SEC) begin
          secIdx <= '0;
          minIdx <= minIdx + 1'b1;
          if (minIdx == LAST_MIN) calLatched <= calValue;
        end else begin
          secIdx <= secIdx + 1'b1;
        end
      end
    end
  end

  // R7
  min_with_sec_chk: assert property (@(posedge clk) disable iff (!rstN)
    minStrobe |-> secStrobe);

  // R7
  min_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    minStrobe |-> (minIdx == MIN_W'($past(minIdx) + 1'b1)));

  // R8
  sec_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    secStrobe |=> !secStrobe);

  // R6
  cal_at_cycle_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(calLatched) |-> (minIdx == '0 && secIdx == '0));
endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
  import rtc_trim_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SEC_PER_MIN   = 60,
  parameter int POS_TRIM      = 256,
  parameter int NEG_TRIM      = 128,
  parameter int TEST_HALF     = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic [5:0] calValue,
  output logic       secStrobe,
  output logic       minStrobe,
  output logic [5:0] minuteInCycle,
  output logic       testClk512
);
  trimCtl_t ctl;
  logic     secEnd;

  rtc_trim_datapath #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .POS_TRIM     (POS_TRIM),
    .NEG_TRIM     (NEG_TRIM),
    .TEST_HALF    (TEST_HALF)
  ) uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .oscTick(oscTick),
    .ctl    (ctl),
    .secEnd (secEnd),
    .testClk(testClk512)
  );

  rtc_trim_control #(
    .SEC_PER_MIN(SEC_PER_MIN)
  ) uControl (
    .clk      (clk),
    .rstN     (rstN),
    .secEnd   (secEnd),
    .calValue (calValue),
    .ctl      (ctl),
    .secStrobe(secStrobe),
    .minStrobe(minStrobe),
    .minIdx   (minuteInCycle)
  );
endmodule

// File: tb/rtc_trim_divider_test.sv
module rtc_trim_divider_test;
  localparam int T    = 64;
  localparam int SEC  = 2;
  localparam int POS  = 8;
  localparam int NEG  = 4;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       gapMode = 1'b0;
  logic       phase = 1'b0;
  logic       oscTick;
  logic [5:0] calValue = 6'd0;
  logic       secStrobe, minStrobe, testClk512;
  logic [5:0] minuteInCycle;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tally = 0;
  int lastSecTally = 0;
  int lastTestTally = 0;
  bit testSeen = 0;
  logic lastTest = 1'b0;
  int bSec = 0;
  int bMin = 0;
  logic [5:0] bCal = 6'd0;

  always #10 clk = ~clk;

  assign oscTick = tickEn & (gapMode ? phase : 1'b1);

  always @(negedge clk) phase <= ~phase;

  rtc_trim_divider #(
    .TICKS_PER_SEC(T), .SEC_PER_MIN(SEC), .POS_TRIM(POS),
    .NEG_TRIM(NEG), .TEST_HALF(HALF)
  ) uut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .calValue(calValue),
    .secStrobe(secStrobe), .minStrobe(minStrobe),
    .minuteInCycle(minuteInCycle), .testClk512(testClk512)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rstN && oscTick) tally <= tally + 1;
  end

  // R9: every half period of the test clock is HALF ticks
  always @(negedge clk) begin
    if (rstN && testClk512 !== lastTest) begin
      if (testSeen)
        check((tally - lastTestTally) == HALF, "R9", "test clock half period",
              tally - lastTestTally, HALF);
      testSeen = 1;
      lastTestTally = tally;
    end
    lastTest = testClk512;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic measureSeconds(int count, string scen);
    for (int i = 0; i < count; i++) begin
      int len, exp;
      int mag;
      bit trimmed;
      string tag;
      do @(negedge clk); while (!secStrobe);
      len = tally - lastSecTally;
      lastSecTally = tally;
      mag = int'(bCal[4:0]);
      trimmed = (bSec == 0) && (mag != 0) && (bMin < 2 * mag);
      if (trimmed) exp = bCal[5] ? T - POS : T + NEG;
      else         exp = T;
      if (trimmed && bCal[5])       tag = "R2";
      else if (trimmed)             tag = "R3";
      else if (bMin < 2 * mag)      tag = "R5";
      else if (mag != 0)            tag = "R4";
      else                          tag = "R1";
      check(len == exp, {scen, "/", tag}, $sformatf("second length m%0d s%0d", bMin, bSec),
            len, exp);
      check(minStrobe == (bSec == SEC - 1), "R7", "minute strobe", minStrobe, bSec == SEC - 1);
      if (bSec == SEC - 1) begin
        bSec = 0;
        if (bMin == 63) begin
          bMin = 0;
          bCal = calValue;
        end else begin
          bMin++;
        end
      end else begin
        bSec++;
      end
      check(minuteInCycle == 6'(bMin), "R7", "minute index", minuteInCycle, bMin);
      @(negedge clk);
      check(secStrobe == 1'b0, "R8", "strobe width", secStrobe, 0);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    calValue = 6'b100101;
    repeat (4) @(negedge clk);
    check(secStrobe == 0, "R10", "reset secStrobe", secStrobe, 0);
    check(minStrobe == 0, "R10", "reset minStrobe", minStrobe, 0);
    check(minuteInCycle == 0, "R10", "reset minute", minuteInCycle, 0);
    check(testClk512 == 0, "R10", "reset test clock", testClk512, 0);
    rstN = 1'b1;
    tickEn = 1'b1;
  endtask

  // first cycle untrimmed although +5 is presented
  task automatic testFirstCycle();
    measureSeconds(64 * SEC, "R6");
  endtask

  // +5 trims minutes 0..9; a mid-cycle change to -2 is ignored
  task automatic testPositive();
    measureSeconds(40, "R2");
    calValue = 6'b000010;
    measureSeconds(64 * SEC - 40, "R6");
  endtask

  task automatic testNegative();
    measureSeconds(64 * SEC - 3, "R3");
    calValue = 6'b111111;
    measureSeconds(3, "R3");
  endtask

  // +31 trims minutes 0..61, never 62 or 63
  task automatic testFull();
    measureSeconds(64 * SEC - 2, "R4");
    calValue = 6'b000001;
    gapMode = 1'b1;
    measureSeconds(2, "R4");
  endtask

  // gapped ticks with -1: lengths in ticks unchanged
  task automatic testGapped();
    measureSeconds(64 * SEC, "R8");
    gapMode = 1'b0;
  endtask

  initial begin
    testReset();
    testFirstCycle();
    testPositive();
    testNegative();
    testFull();
    testGapped();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule